// File: doc/BRIEF.md
# Masked Associative Memory Array

This block is a small fully parallel content-addressable memory. It holds WORDS words of WIDTH bits, and every word has its own comparison and update logic. A search compares each word against a comparand register in the same clock. Only the bit columns enabled by a per-bit mask register take part, and only the words enabled by a per-word select register can respond. Each word that matches raises its tag bit.

The tags then drive the other operations. A parallel multi-write puts the masked comparand bits into every tagged word at once. A read copies one tagged word into an output register. A priority resolver reduces the tags to one winner, the lowest-numbered tagged word, and gives it both as a one-hot vector and as a binary index. An aggregate flag shows whether any word responded. Words are loaded one at a time by address. All commands arrive on one synchronous port: a valid strobe, a 3-bit operation code and data fields. Each command completes in one clock.

Top module: `assoc_array`

## Requirements
- R1: After synchronous reset, all words, tags, the read register and the comparand are zero, the resolver outputs are zero, and the mask and select registers are all ones.
- R2: A search (op code 5) sets tag j to 1 exactly when select bit j is 1 and word j equals the comparand in every column whose mask bit is 1. Otherwise tag j is set to 0.
- R3: Columns whose mask bit is 0 do not affect a search and keep their stored value during a multi-write. The mask is loaded from the data field by op code 2.
- R4: A word whose select bit is 0 never gets its tag set and is never changed by a multi-write. The select register is loaded from the select field by op code 3.
- R5: A multi-write (op code 6) writes the comparand into every masked column of every tagged, selected word, all in the same clock. The comparand is loaded from the data field by op code 1.
- R6: A read (op code 7) loads the read register with the full contents of the lowest-numbered tagged word, or with zero when no tag is set.
- R7: The some flag is 1 exactly when at least one tag bit is 1.
- R8: The resolver outputs a one-hot vector that marks the lowest-numbered tagged word, and the binary index of that word. Both are zero when no tag is set.
- R9: A clear-tags command (op code 4) makes every tag bit zero.
- R10: A load (op code 0) writes the data field into the word at the given address. The mask, the select register and the tags have no effect on it, and it does not change any tag.
- R11: The results of a command are visible at the outputs right after the clock edge that takes it. Tags hold their value through commands that are not search or clear-tags commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | Operation code (0 load, 1 comparand, 2 mask, 3 select, 4 clear tags, 5 search, 6 multi-write, 7 read) |
| cmd_addr | input | $clog2(WORDS) | Word address for a load |
| cmd_data | input | WIDTH | Load data, comparand or mask value |
| cmd_sel | input | WORDS | New value for the word-select register |
| tag_o | output | WORDS | Tag (response) bits, one per word |
| some_o | output | 1 | At least one tag is set |
| first_hot_o | output | WORDS | One-hot vector of the lowest-numbered tagged word |
| first_idx_o | output | $clog2(WORDS) | Binary index of the lowest-numbered tagged word |
| rd_data_o | output | WIDTH | Read register |

## Verification
The bench builds the array with four words of four bits. At that size every comparand value can be crossed with every mask value in a search, and every select pattern can be tried, so each match combination is covered. After each multi-write, searching for all sixteen word values with the full mask reads back every word through the normal port, without any access to internal state. A bench model of the four words gives the expected tags, resolver outputs and read data by arithmetic.

// File: rtl/assoc_pkg.sv
package assoc_pkg;

    typedef enum logic [2:0] {
        OP_LOAD   = 3'd0,
        OP_CMP    = 3'd1,
        OP_MASK   = 3'd2,
        OP_SEL    = 3'd3,
        OP_CLRTAG = 3'd4,
        OP_SEARCH = 3'd5,
        OP_MWRITE = 3'd6,
        OP_READ   = 3'd7
    } assoc_op_e;

    typedef struct packed {
        logic load;
        logic set_cmp;
        logic set_mask;
        logic set_sel;
        logic clr;
        logic search;
        logic mwrite;
        logic read;
    } op_strobe_t;

    function automatic op_strobe_t decode_op(input logic valid, input assoc_op_e op);
        op_strobe_t s;
        s = '0;
        if (valid) begin
            unique case (op)
                OP_LOAD:   s.load     = 1'b1;
                OP_CMP:    s.set_cmp  = 1'b1;
                OP_MASK:   s.set_mask = 1'b1;
                OP_SEL:    s.set_sel  = 1'b1;
                OP_CLRTAG: s.clr      = 1'b1;
                OP_SEARCH: s.search   = 1'b1;
                OP_MWRITE: s.mwrite   = 1'b1;
                OP_READ:   s.read     = 1'b1;
                default:   s = '0;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/assoc_word.sv
module assoc_word #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic             search_en,
    input  logic             mwrite_en,
    input  logic             clr_en,
    input  logic             sel,
    input  logic [WIDTH-1:0] load_data,
    input  logic [WIDTH-1:0] cmp,
    input  logic [WIDTH-1:0] mask,
    output logic [WIDTH-1:0] word_q,
    output logic             tag_q
);

    logic             hit;
    logic [WIDTH-1:0] merged;

    // A column disagrees only if it differs and is enabled.
    assign hit    = ~|((word_q ^ cmp) & mask);
    assign merged = (word_q & ~mask) | (cmp & mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (load_en) begin
            word_q <= load_data;
        end else if (mwrite_en && tag_q && sel) begin
            word_q <= merged;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q <= 1'b0;
        end else if (clr_en) begin
            tag_q <= 1'b0;
        end else if (search_en) begin
            tag_q <= sel && hit;
        end
    end

    // R5
    mwrite_sets_cols_chk: assert property (@(posedge clk) disable iff (rst)
        (mwrite_en && tag_q && sel && !load_en) |=> (((word_q ^ $past(cmp)) & $past(mask)) == '0));

    // R3
    unmasked_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (mwrite_en && !load_en) |=> (((word_q ^ $past(word_q)) & ~$past(mask)) == '0));

    // R4
    unselected_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (mwrite_en && !sel && !load_en) |=> $stable(word_q));

    // R4
    unselected_no_tag_chk: assert property (@(posedge clk) disable iff (rst)
        (search_en && !sel && !clr_en) |=> !tag_q);

    // R9
    clear_tag_chk: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> !tag_q);

endmodule

// File: rtl/assoc_resolver.sv
module assoc_resolver #(
    parameter int WORDS = 8,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic [WORDS-1:0] req,
    output logic [WORDS-1:0] grant_o,
    output logic [IDX_W-1:0] idx_o
);

    always_comb begin
        grant_o = '0;
        idx_o   = '0;
        for (int i = WORDS - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant_o    = '0;
                grant_o[i] = 1'b1;
                idx_o      = IDX_W'(i);
            end
        end
    end

    always_comb begin
        // R8
        grant_onehot_chk: assert ($onehot0(grant_o));
        // R8
        grant_in_req_chk: assert ((grant_o & ~req) == '0);
        // R8
        grant_idx_agree_chk: assert ((grant_o == '0) ? (idx_o == '0) : grant_o[idx_o]);
    end

endmodule

// File: rtl/assoc_array.sv
module assoc_array
    import assoc_pkg::*;
#(
    parameter int WORDS = 8,
    parameter int WIDTH = 16,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [IDX_W-1:0] cmd_addr,
    input  logic [WIDTH-1:0] cmd_data,
    input  logic [WORDS-1:0] cmd_sel,
    output logic [WORDS-1:0] tag_o,
    output logic             some_o,
    output logic [WORDS-1:0] first_hot_o,
    output logic [IDX_W-1:0] first_idx_o,
    output logic [WIDTH-1:0] rd_data_o
);

    op_strobe_t       st;
    logic [WIDTH-1:0] cmp_q;
    logic [WIDTH-1:0] mask_q;
    logic [WORDS-1:0] sel_q;
    logic [WIDTH-1:0] rd_q;
    logic [WIDTH-1:0] word_vec [WORDS];

    assign st = decode_op(cmd_valid, assoc_op_e'(cmd_op));

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q  <= '0;
            mask_q <= '1;
            sel_q  <= '1;
        end else begin
            if (st.set_cmp)  cmp_q  <= cmd_data;
            if (st.set_mask) mask_q <= cmd_data;
            if (st.set_sel)  sel_q  <= cmd_sel;
        end
    end

    for (genvar j = 0; j < WORDS; j++) begin : g_word
        assoc_word #(.WIDTH(WIDTH)) u_word (
            .clk       (clk),
            .rst       (rst),
            .load_en   (st.load && (cmd_addr == IDX_W'(j))),
            .search_en (st.search),
            .mwrite_en (st.mwrite),
            .clr_en    (st.clr),
            .sel       (sel_q[j]),
            .load_data (cmd_data),
            .cmp       (cmp_q),
            .mask      (mask_q),
            .word_q    (word_vec[j]),
            .tag_q     (tag_o[j])
        );
    end

    assoc_resolver #(.WORDS(WORDS)) u_resolve (
        .req     (tag_o),
        .grant_o (first_hot_o),
        .idx_o   (first_idx_o)
    );

    assign some_o = |tag_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (st.read) begin
            rd_q <= some_o ? word_vec[first_idx_o] : '0;
        end
    end

    assign rd_data_o = rd_q;

    // R6
    read_empty_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (st.read && !some_o) |=> (rd_data_o == '0));

    // R8
    winner_tagged_chk: assert property (@(posedge clk) disable iff (rst)
        some_o |-> (tag_o[first_idx_o] && first_hot_o != '0));

    // R11
    tags_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(st.search || st.clr) |=> $stable(tag_o));

endmodule

// File: tb/sim_assoc_array.sv
`timescale 1ns/100ps
module sim_assoc_array;

    localparam int K = 4;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cmd_valid = 1'b0;
    logic [2:0]   cmd_op = '0;
    logic [1:0]   cmd_addr = '0;
    logic [N-1:0] cmd_data = '0;
    logic [K-1:0] cmd_sel = '0;
    logic [K-1:0] tag_o;
    logic         some_o;
    logic [K-1:0] first_hot_o;
    logic [1:0]   first_idx_o;
    logic [N-1:0] rd_data_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [N-1:0] mem [K];

    always #2.5 clk = ~clk;

    assoc_array #(.WORDS(K), .WIDTH(N)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_sel(cmd_sel),
        .tag_o(tag_o), .some_o(some_o), .first_hot_o(first_hot_o),
        .first_idx_o(first_idx_o), .rd_data_o(rd_data_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_cmd(input logic [2:0] op, input logic [N-1:0] data,
                          input logic [1:0] addr, input logic [K-1:0] sel);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_data  = data;
        cmd_addr  = addr;
        cmd_sel   = sel;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    function automatic logic [K-1:0] exp_tags(input logic [N-1:0] c, input logic [N-1:0] m,
                                              input logic [K-1:0] s);
        logic [K-1:0] t;
        for (int j = 0; j < K; j++) t[j] = s[j] && (((mem[j] ^ c) & m) == '0);
        return t;
    endfunction

    function automatic int low_idx(input logic [K-1:0] t);
        for (int j = 0; j < K; j++) if (t[j]) return j;
        return 0;
    endfunction

    // Checks tags, flag, resolver outputs, then a read of the winner.
    task automatic check_resp(input logic [K-1:0] et);
        logic [K-1:0] hot;
        hot = (et == '0) ? '0 : K'(1) << low_idx(et);
        chk("R2", int'(tag_o), int'(et));
        chk("R7", int'(some_o), int'(et != '0));
        chk("R8 onehot", int'(first_hot_o), int'(hot));
        chk("R8 index", int'(first_idx_o), low_idx(et));
        do_cmd(3'd7, '0, '0, '0);
        chk("R6", int'(rd_data_o), (et == '0) ? 0 : int'(mem[low_idx(et)]));
    endtask

    // Confirms all stored words through full-mask exact searches.
    task automatic verify_all(input string req);
        do_cmd(3'd3, '0, '0, '1);
        do_cmd(3'd2, '1, '0, '0);
        for (int v = 0; v < 16; v++) begin
            do_cmd(3'd1, N'(v), '0, '0);
            do_cmd(3'd5, '0, '0, '0);
            chk(req, int'(tag_o), int'(exp_tags(N'(v), '1, '1)));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 tags", int'(tag_o), 0);
        chk("R1 some", int'(some_o), 0);
        chk("R1 hot", int'(first_hot_o), 0);
        chk("R1 idx", int'(first_idx_o), 0);
        chk("R1 rd", int'(rd_data_o), 0);
        for (int j = 0; j < K; j++) mem[j] = '0;
        // R1: zero comparand, full mask and select find every zero word
        do_cmd(3'd5, '0, '0, '0);
        chk("R1 defaults", int'(tag_o), 4'hF);

        // R10 load words
        mem[0] = 4'h3; mem[1] = 4'hA; mem[2] = 4'h3; mem[3] = 4'hF;
        for (int j = 0; j < K; j++) do_cmd(3'd0, mem[j], 2'(j), '0);
        chk("R10 tags kept", int'(tag_o), 4'hF);
        do_cmd(3'd4, '0, '0, '0);
        chk("R9", int'(tag_o), 0);
        do_cmd(3'd1, 4'h3, '0, '0);
        do_cmd(3'd5, '0, '0, '0);
        chk("R10 contents", int'(tag_o), 4'b0101);
        // R11 tags hold through a non-search command
        do_cmd(3'd1, 4'hA, '0, '0);
        chk("R11", int'(tag_o), 4'b0101);

        // R2 R3 exhaustive comparand x mask sweep
        for (int m = 0; m < 16; m++) begin
            do_cmd(3'd2, N'(m), '0, '0);
            for (int c = 0; c < 16; c++) begin
                do_cmd(3'd1, N'(c), '0, '0);
                do_cmd(3'd5, '0, '0, '0);
                check_resp(exp_tags(N'(c), N'(m), '1));
            end
        end

        // R4 select sweep
        do_cmd(3'd2, '1, '0, '0);
        do_cmd(3'd1, 4'h3, '0, '0);
        for (int s = 0; s < 16; s++) begin
            do_cmd(3'd3, '0, '0, K'(s));
            do_cmd(3'd5, '0, '0, '0);
            chk("R4 search", int'(tag_o), int'(exp_tags(4'h3, '1, K'(s))));
        end

        // R5 R3 R4 multi-write sweep
        for (int k = 0; k < 16; k++) begin
            logic [K-1:0] t;
            logic [K-1:0] s;
            logic [N-1:0] wc;
            s  = K'(~k | 1);
            do_cmd(3'd3, '0, '0, s);
            do_cmd(3'd2, 4'b0011, '0, '0);
            do_cmd(3'd1, N'(k), '0, '0);
            do_cmd(3'd5, '0, '0, '0);
            t = exp_tags(N'(k), 4'b0011, s);
            chk("R4 tags", int'(tag_o), int'(t));
            wc = N'(k * 5 + 1);
            do_cmd(3'd1, wc, '0, '0);
            do_cmd(3'd2, N'(k), '0, '0);
            do_cmd(3'd6, '0, '0, '0);
            for (int j = 0; j < K; j++)
                if (t[j] && s[j]) mem[j] = (mem[j] & ~N'(k)) | (wc & N'(k));
            verify_all("R5");
            // reseed so later rounds have several matches
            if (k % 4 == 3)
                for (int j = 0; j < K; j++) begin
                    mem[j] = N'(j * 3 + k);
                    do_cmd(3'd0, mem[j], 2'(j), '0);
                end
        end

        // R5 all words written in one command, masked write of every word
        do_cmd(3'd2, 4'b0000, '0, '0);
        do_cmd(3'd5, '0, '0, '0);
        chk("R5 all tagged", int'(tag_o), 4'hF);
        do_cmd(3'd1, 4'b0110, '0, '0);
        do_cmd(3'd2, 4'b0110, '0, '0);
        do_cmd(3'd6, '0, '0, '0);
        for (int j = 0; j < K; j++) mem[j] = (mem[j] & 4'b1001) | 4'b0110;
        verify_all("R5 one cycle");

        // R6 read with no tags
        do_cmd(3'd4, '0, '0, '0);
        chk("R9 cleared", int'(tag_o), 0);
        do_cmd(3'd7, '0, '0, '0);
        chk("R6 empty", int'(rd_data_o), 0);
        chk("R8 empty idx", int'(first_idx_o), 0);

        // R10 load ignores mask and select
        do_cmd(3'd2, '0, '0, '0);
        do_cmd(3'd3, '0, '0, '0);
        do_cmd(3'd0, 4'h9, 2'd2, '0);
        mem[2] = 4'h9;
        verify_all("R10 load");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule